// File: doc/BRIEF.md
# Reed-Solomon 12-bit Symbol Error Applier

This block sits after a Reed-Solomon decoder whose symbols are 12 bits wide. The decoder finds the error locations and their patterns. This block takes those results and repairs a byte-addressed page buffer in place. Two 12-bit symbols pack into three bytes, so a symbol index has to be turned into one or two byte addresses and nibble-aligned masks. Which bytes are touched depends on whether the index is odd or even.

The buffer is one flat byte space. It holds a 2048-byte main area, and the spare area follows it at address 2048. Because the spare area starts exactly where the main area ends, the symbol that spans the two areas and every spare-area symbol follow the same packing rule as the main area.

Corrections arrive as a stream of (position, pattern) beats and end with an end-marker beat. Each byte update is a one-cycle read followed by a write of the read value XOR the mask. When the end marker arrives, the block reports either the number of symbols it corrected or a failure.

Top module: `rs12_err_apply`

## Requirements
- R1: For an odd position p, byte floor(3p/2) is XORed with pattern bits [11:4], and byte floor(3p/2)+1 is XORed with {pattern[3:0], 4'b0000}.
- R2: For an even position p other than 0, byte 3p/2-1 is XORed with {4'b0000, pattern[11:8]}, and byte 3p/2 is XORed with pattern[7:0].
- R3: Position 0 writes exactly one byte, address 0, XORed with pattern[7:0]. A pair at position 0 keeps the input port not-ready for 2 cycles.
- R4: A pattern with any of bits [11:8] set at position 0 makes the page uncorrectable.
- R5: Position 1365 updates byte 2047 with pattern[11:4] and byte 2048 (the first spare byte) with the low nibble in the upper half.
- R6: Positions 1366 to 1374 update spare bytes using the R1/R2 rules on the flat address space, and no access ever leaves the buffer.
- R7: Any position above 1374 makes the page uncorrectable.
- R8: At most 4 symbols are corrected per page. A fifth valid pair makes the page uncorrectable.
- R9: Once a page is uncorrectable, no further memory writes occur for it. The remaining pairs are still accepted until the end marker.
- R10: Accepting the end marker raises `done` for the next cycle. `corr_cnt` and `fail` then hold the page result: the corrected count, or 0 with `fail` set. The next page starts clean.
- R11: Each byte update is a read, then in the very next cycle a write to the same address. The write data is the read data XOR the mask, and read data returns one cycle after the read.
- R12: Out of reset, `in_ready` is 1 and `done`, `mem_rd` and `mem_we` are 0. While a pair is being applied, `in_ready` is 0 for 4 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can accept a beat |
| in_end | input | 1 | Beat is the end-of-page marker |
| in_pos | input | 11 | Symbol position |
| in_pat | input | 12 | Symbol error pattern |
| mem_addr | output | 12 | Buffer byte address |
| mem_rd | output | 1 | Buffer read request |
| mem_rdata | input | 8 | Read data, one cycle after `mem_rd` |
| mem_we | output | 1 | Buffer write strobe |
| mem_wdata | output | 8 | Write data |
| done | output | 1 | One-cycle page-complete pulse |
| fail | output | 1 | Page uncorrectable (held) |
| corr_cnt | output | 3 | Symbols corrected on the last page (held) |

## Verification
The page result is due in the cycle right after the end marker is accepted. The bench drives each beat at a falling edge and samples `done`, `fail` and `corr_cnt` at the very next falling edge. After a pair is accepted, the bench counts falling edges with `in_ready` low and expects 4, or 2 for position 0. The bench's buffer model returns read data one cycle after a read. The whole buffer and the running write count are compared against an arithmetic reference only once the page result has appeared, after every write for that page has landed.

// File: rtl/rs12_err_apply.sv
module rs12_err_apply #(
  parameter int MAIN_BYTES  = 2048,
  parameter int SPARE_BYTES = 64,
  parameter int MAX_POS     = 1374,
  parameter int MAX_ERR     = 4,
  parameter int POS_W       = 11,
  localparam int SYM_W      = 12,
  localparam int CNT_W      = $clog2(MAX_ERR + 1),
  localparam int ADDR_W     = $clog2(MAIN_BYTES + SPARE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_end,
  input  logic [POS_W-1:0]  in_pos,
  input  logic [SYM_W-1:0]  in_pat,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  input  logic [7:0]        mem_rdata,
  output logic              mem_we,
  output logic [7:0]        mem_wdata,
  output logic              done,
  output logic              fail,
  output logic [CNT_W-1:0]  corr_cnt
);

  typedef enum logic [2:0] {S_IDLE, S_RD0, S_WR0, S_RD1, S_WR1} st_t;
  st_t st;

  logic [ADDR_W-1:0] a0, a1;
  logic [7:0]        d0, d1;
  logic [CNT_W-1:0]  cnt;
  logic              bad;

  wire              take   = in_valid && in_ready;
  wire [POS_W+1:0]  triple = ({2'b00, in_pos} << 1) + {2'b00, in_pos};
  wire [POS_W+1:0]  half   = triple >> 1;
  wire [ADDR_W-1:0] base   = half[ADDR_W-1:0];
  wire              odd    = in_pos[0];
  wire              at0    = (in_pos == '0);
  wire              reject = (in_pos > POS_W'(MAX_POS)) || (at0 && in_pat[11:8] != 4'h0)
                             || (cnt == CNT_W'(MAX_ERR));

  assign in_ready  = (st == S_IDLE);
  assign mem_rd    = (st == S_RD0) || (st == S_RD1);
  assign mem_we    = (st == S_WR0) || (st == S_WR1);
  assign mem_addr  = (st == S_RD0 || st == S_WR0) ? a0 : a1;
  assign mem_wdata = mem_rdata ^ ((st == S_WR0) ? d0 : d1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      a0       <= '0;
      a1       <= '0;
      d0       <= '0;
      d1       <= '0;
      cnt      <= '0;
      bad      <= 1'b0;
      done     <= 1'b0;
      fail     <= 1'b0;
      corr_cnt <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (take) begin
          if (in_end) begin
            done     <= 1'b1;
            fail     <= bad;
            corr_cnt <= bad ? '0 : cnt;
            bad      <= 1'b0;
            cnt      <= '0;
          end else if (!bad) begin
            if (reject) begin
              bad <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
              a0  <= odd ? base : base - 1'b1;
              a1  <= odd ? base + 1'b1 : base;
              d0  <= odd ? in_pat[11:4] : {4'h0, in_pat[11:8]};
              d1  <= odd ? {in_pat[3:0], 4'h0} : in_pat[7:0];
              st  <= at0 ? S_RD1 : S_RD0;
            end
          end
        end
        S_RD0:   st <= S_WR0;
        S_WR0:   st <= S_RD1;
        S_RD1:   st <= S_WR1;
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

module rs12_err_apply_chk #(
  parameter int MAX_ERR   = 4,
  parameter int BUF_BYTES = 2112,
  parameter int CNT_W     = 3,
  parameter int ADDR_W    = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rd,
  input logic              mem_we,
  input logic              done,
  input logic              fail,
  input logic [CNT_W-1:0]  corr_cnt
);
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(mem_rd && mem_we)); // R11
  AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (!rst_n) mem_rd |=> mem_we); // R11
  AST_WR_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($past(mem_rd) && mem_addr == $past(mem_addr))); // R11
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_we) |-> !in_ready); // R12
  AST_ADDR_IN_BUF: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_we) |-> (mem_addr < ADDR_W'(BUF_BYTES))); // R6
  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (corr_cnt <= CNT_W'(MAX_ERR))); // R8
  AST_FAIL_ZERO_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fail) |-> (corr_cnt == '0)); // R10
endmodule

bind rs12_err_apply rs12_err_apply_chk #(
  .MAX_ERR(MAX_ERR), .BUF_BYTES(MAIN_BYTES + SPARE_BYTES), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .mem_addr(mem_addr), .mem_rd(mem_rd),
  .mem_we(mem_we), .done(done), .fail(fail), .corr_cnt(corr_cnt)
);

// File: tb/rs12_err_apply_bench.sv
module rs12_err_apply_bench;
  localparam int NBYTES = 2112;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0, in_end = 0;
  logic        in_ready;
  logic [10:0] in_pos = '0;
  logic [11:0] in_pat = '0;
  logic [11:0] mem_addr;
  logic        mem_rd, mem_we;
  logic [7:0]  mem_rdata = '0, mem_wdata;
  logic        done, fail;
  logic [2:0]  corr_cnt;

  always #2 clk = ~clk;

  rs12_err_apply u_rs12_err_apply (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_end(in_end),
    .in_pos(in_pos), .in_pat(in_pat), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_wdata(mem_wdata), .done(done),
    .fail(fail), .corr_cnt(corr_cnt)
  );

  function automatic logic [7:0] seed_byte(int a);
    return 8'(a * 7 + 3) ^ 8'(a >> 3);
  endfunction

  logic [7:0] mem [0:NBYTES-1];
  logic [7:0] sh  [0:NBYTES-1];
  int wr_total = 0;
  int cyc = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < NBYTES; a++) mem[a] <= seed_byte(a);
    end else begin
      if (mem_we) begin
        mem[mem_addr] <= mem_wdata;
        wr_total <= wr_total + 1;
      end
      if (mem_rd) mem_rdata <= mem[mem_addr];
    end
  end

  int vectors = 0, miscompares = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares + 1);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic ref_apply(input int p, input logic [11:0] pt);
    int b;
    if (p == 0) sh[0] ^= pt[7:0];
    else if (p == 1365) begin
      sh[2047] ^= pt[11:4];
      sh[2048] ^= {pt[3:0], 4'h0};
    end else begin
      b = (p * 3) / 2;
      if (p % 2 == 1) begin
        sh[b]     ^= pt[11:4];
        sh[b + 1] ^= {pt[3:0], 4'h0};
      end else begin
        sh[b - 1] ^= {4'h0, pt[11:8]};
        sh[b]     ^= pt[7:0];
      end
    end
  endtask

  task automatic send_beat(input logic e, input int p, input logic [11:0] pt);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_end = e; in_pos = 11'(p); in_pat = pt;
    @(negedge clk);
    in_valid = 0; in_end = 0;
  endtask

  int pg_pos [0:7];
  logic [11:0] pg_pat [0:7];

  task automatic run_page(input int n, input string tag);
    int w0, c, ew, bad_at, mism;
    bit bad;
    w0 = wr_total; c = 0; ew = 0; bad = 0; bad_at = -1; mism = 0;
    for (int i = 0; i < n; i++) begin
      send_beat(0, pg_pos[i], pg_pat[i]);
      if (!bad) begin
        if (pg_pos[i] > 1374 || (pg_pos[i] == 0 && pg_pat[i] > 12'hFF) || c == 4) bad = 1;
        else begin
          ref_apply(pg_pos[i], pg_pat[i]);
          c++;
          ew += (pg_pos[i] == 0) ? 1 : 2;
        end
      end
    end
    send_beat(1, 0, 12'h0);
    chk(done === 1'b1, "R10", {tag, " done pulse"}, int'(done), 1);
    chk(fail === bad, tag, "fail flag", int'(fail), int'(bad));
    chk(corr_cnt == 3'(bad ? 0 : c), tag, "corrected count", int'(corr_cnt), bad ? 0 : c);
    chk(wr_total - w0 == ew, bad ? "R9" : "R11", {tag, " write count"}, wr_total - w0, ew);
    for (int a = 0; a < NBYTES; a++)
      if (mem[a] !== sh[a]) begin
        if (bad_at < 0) bad_at = a;
        mism++;
      end
    chk(mism == 0, tag, "buffer bytes differing (first addr below)", bad_at, -1);
  endtask

  function automatic string tag_of(int p);
    if (p == 0) return "R3";
    if (p == 1365) return "R5";
    if (p > 1365) return "R6";
    return (p % 2 == 1) ? "R1" : "R2";
  endfunction

  initial begin
    int lo;
    for (int a = 0; a < NBYTES; a++) sh[a] = seed_byte(a);
    repeat (3) @(negedge clk);
    chk(in_ready === 1'b1, "R12", "reset in_ready", int'(in_ready), 1);
    chk(done === 1'b0 && mem_rd === 1'b0 && mem_we === 1'b0, "R12", "reset idle outputs",
        int'({done, mem_rd, mem_we}), 0);
    rst_n = 1;

    // sweep every legal position with one error per page
    for (int p = 0; p <= 1374; p++) begin
      pg_pos[0] = p;
      pg_pat[0] = (p == 0) ? 12'h0A5 : (12'(p * 91 + 12'h5A7) | 12'h001);
      run_page(1, tag_of(p));
    end

    // busy window lengths
    send_beat(0, 5, 12'h3C1);
    ref_apply(5, 12'h3C1);
    lo = 0;
    while (!in_ready) begin lo++; @(negedge clk); end
    chk(lo == 4, "R12", "busy cycles for odd pair", lo, 4);
    send_beat(1, 0, 12'h0);
    send_beat(0, 0, 12'h077);
    ref_apply(0, 12'h077);
    lo = 0;
    while (!in_ready) begin lo++; @(negedge clk); end
    chk(lo == 2, "R3", "busy cycles for position 0", lo, 2);
    send_beat(1, 0, 12'h0);

    // position 0 with high bits set
    pg_pos[0] = 0; pg_pat[0] = 12'h1FF;
    run_page(1, "R4");
    // positions beyond the limit
    pg_pos[0] = 1375; pg_pat[0] = 12'h123;
    run_page(1, "R7");
    pg_pos[0] = 2047; pg_pat[0] = 12'hFFF;
    run_page(1, "R7");
    // empty page after failure: clean result
    run_page(0, "R10");
    // four errors: boundary count
    pg_pos[0] = 1;    pg_pat[0] = 12'hABC;
    pg_pos[1] = 2;    pg_pat[1] = 12'h9F1;
    pg_pos[2] = 1365; pg_pat[2] = 12'h5E3;
    pg_pos[3] = 1374; pg_pat[3] = 12'hC0D;
    run_page(4, "R8");
    // five errors: uncorrectable, first four stay applied
    pg_pos[4] = 700; pg_pat[4] = 12'h111;
    run_page(5, "R8");
    // failure in the middle blocks later writes
    pg_pos[0] = 10;   pg_pat[0] = 12'h0F0;
    pg_pos[1] = 1400; pg_pat[1] = 12'h222;
    pg_pos[2] = 11;   pg_pat[2] = 12'h333;
    run_page(3, "R9");
    // mixed page with position 0 and spare symbols
    pg_pos[0] = 0;    pg_pat[0] = 12'h0FF;
    pg_pos[1] = 1367; pg_pat[1] = 12'h8A5;
    pg_pos[2] = 1366; pg_pat[2] = 12'h4B6;
    run_page(3, "R6");
    // result held while idle
    repeat (5) @(negedge clk);
    chk(corr_cnt == 3'd3 && fail === 1'b0 && done === 1'b0, "R10", "result held",
        int'({fail, corr_cnt}), 3);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule